// File: doc/BRIEF.md
# CAN Controller Interrupt and Command Unit

This block is the control and status core of a byte-register CAN controller. It holds the mode, status, interrupt and interrupt-enable registers behind a small synchronous register port. It turns one-shot command writes into a transmit request, a receive-message release and an overrun clear. It also drives a level-sensitive interrupt line. Strobes from the receive FIFO (frame begun, stored, rejected, overrun) and from the transmit path (done) update its status and interrupt bits. It keeps its own count of buffered messages, so it knows when the receive-buffer indication has to fall.

The register port has an 8-bit data bus and a 5-bit address, and read data appears one cycle after the read strobe. The port takes at most one read and one write per cycle and never stalls, so there is no back-pressure. The event inputs are single-cycle strobes with no handshake, and the outputs `tx_req`, `rx_release` and `op_enter` are single-cycle pulses for the neighbouring FIFO and transmit logic. The register addresses are: mode 0x00, command 0x01, status 0x02, interrupt 0x03, interrupt enable 0x04, first transmit-buffer byte 0x10. Every other address reads 0x00.

Top module: `can_ctl_core`

## Requirements
- R1: After reset the mode reads 0x01 (bit 0 = reset mode), the status reads 0x3C, the interrupt register reads 0x00 and `irq` is low.
- R2: `irq` is high exactly when some bit is set in both the interrupt-enable register and the interrupt register, and it follows every change of either register.
- R3: A command write with bit 0 set pulses `tx_req` in the next cycle and clears status bits 3:2. A `tx_done` strobe sets status bits 3:2, clears status bit 5 and sets interrupt bit 1.
- R4: A command write with bit 2 set while messages are buffered pulses `rx_release` and decrements the message count. When the count reaches zero, status bit 0 and interrupt bit 0 clear. With no message buffered, the release does nothing.
- R5: A command write with bit 3 set clears status bit 1 (overrun) and interrupt bit 3.
- R6: `rx_overrun` sets status bit 1 and interrupt bit 3. `rx_stored` increments the message count and sets status bit 0 and interrupt bit 0. `rx_begin` sets status bit 4, and any outcome strobe (stored, overrun, rejected) clears it.
- R7: The command register reads 0x00. Writes to the status and interrupt registers have no effect. A mode write keeps only its low 5 bits.
- R8: A write to the first transmit-buffer byte (0x10) sets status bit 5 in operating mode and leaves the status unchanged in reset mode.
- R9: A mode write that changes bit 0 from 1 to 0 pulses `op_enter` in the next cycle and empties the message count, which clears status bit 0 and interrupt bit 0.
- R10: Several command bits in one write are applied in the same cycle, in the order transmit, release, clear-overrun.
- R11: Reading the interrupt register returns its value and clears it. Interrupt bit 0 is set again at once while messages remain buffered.
- R12: Read data for the addressed register appears on `rdata` one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 5 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, one cycle after rd_en |
| irq | output | 1 | Level interrupt |
| mode | output | 5 | Current mode register, bit 0 = reset mode |
| tx_req | output | 1 | Transmit request pulse |
| tx_done | input | 1 | Transmit path finished strobe |
| rx_begin | input | 1 | Incoming frame handling started |
| rx_stored | input | 1 | Frame stored in receive FIFO |
| rx_overrun | input | 1 | Frame dropped, FIFO full |
| rx_reject | input | 1 | Frame dropped by filter |
| rx_release | output | 1 | Pulse: free oldest stored message |
| op_enter | output | 1 | Pulse: leaving reset mode, flush counters and reload filters |

## Verification
The embedded properties check on every cycle that the command register reads zero, that a transmit command clears the completion bits, and that `tx_done`, overrun set and overrun clear reach the status and interrupt bits. They also check that `irq` stays low with nothing enabled and that entering operating mode drops the buffered-message indication. Only the bench scenarios can show the message-count bookkeeping across several stores and releases, the re-assertion of the receive interrupt after a clearing read, the ordering of a multi-bit command, and the mode-dependent effect of a transmit-buffer write.

// File: rtl/can_ctl_pkg.sv
package can_ctl_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam int MODE_W = 5;

  typedef logic [ADDR_W-1:0] reg_addr_t;

  localparam reg_addr_t A_MODE = 5'h00;
  localparam reg_addr_t A_CMD  = 5'h01;
  localparam reg_addr_t A_STAT = 5'h02;
  localparam reg_addr_t A_INT  = 5'h03;
  localparam reg_addr_t A_IEN  = 5'h04;
  localparam reg_addr_t A_TXB0 = 5'h10;

  localparam int ST_RXBUF  = 0;
  localparam int ST_OVR    = 1;
  localparam int ST_TXCMP  = 2;
  localparam int ST_TXBUF  = 3;
  localparam int ST_RXACT  = 4;
  localparam int ST_TXACT  = 5;

  localparam int IR_RX  = 0;
  localparam int IR_TX  = 1;
  localparam int IR_OVR = 3;

  localparam logic [DATA_W-1:0] STAT_RST = 8'h3C;
  localparam logic [MODE_W-1:0] MODE_RST = 5'h01;

  typedef struct packed {
    logic tx;
    logic rel;
    logic clr;
  } cmd_t;
endpackage

// File: rtl/can_ctl_regbus.sv
module can_ctl_regbus
  import can_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  reg_addr_t         addr,
  input  logic [MODE_W-1:0] mode,
  input  logic [DATA_W-1:0] stat,
  input  logic [DATA_W-1:0] ireg,
  input  logic [DATA_W-1:0] ien,
  output logic              wr_mode,
  output logic              wr_cmd,
  output logic              wr_ien,
  output logic              wr_txb0,
  output logic              rd_int,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rd_mux;

  assign wr_mode = wr_en && (addr == A_MODE);
  assign wr_cmd  = wr_en && (addr == A_CMD);
  assign wr_ien  = wr_en && (addr == A_IEN);
  assign wr_txb0 = wr_en && (addr == A_TXB0);
  assign rd_int  = rd_en && (addr == A_INT);

  always_comb begin
    case (addr)
      A_MODE:  rd_mux = DATA_W'(mode);
      A_STAT:  rd_mux = stat;
      A_INT:   rd_mux = ireg;
      A_IEN:   rd_mux = ien;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  p_cmd_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_CMD) |=> (rdata == '0));
endmodule

// File: rtl/can_ctl_mode.sv
module can_ctl_mode
  import can_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_mode,
  input  logic              wr_ien,
  input  logic [DATA_W-1:0] wdata,
  output logic [MODE_W-1:0] mode,
  output logic [DATA_W-1:0] ien,
  output logic              leave_rst,
  output logic              op_enter
);
  assign leave_rst = wr_mode && mode[0] && !wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= MODE_RST;
      ien      <= '0;
      op_enter <= 1'b0;
    end else begin
      if (wr_mode) mode <= wdata[MODE_W-1:0];
      if (wr_ien)  ien  <= wdata;
      op_enter <= leave_rst;
    end
  end
endmodule

// File: rtl/can_ctl_cmd.sv
module can_ctl_cmd
  import can_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_cmd,
  input  logic [2:0] cmd_bits,
  output cmd_t       cmd,
  output logic       tx_req
);
  // cmd_bits = {clear-overrun, release, transmit}
  assign cmd.tx  = wr_cmd && cmd_bits[0];
  assign cmd.rel = wr_cmd && cmd_bits[1];
  assign cmd.clr = wr_cmd && cmd_bits[2];

  always_ff @(posedge clk) begin
    if (!rst_n) tx_req <= 1'b0;
    else        tx_req <= cmd.tx;
  end
endmodule

// File: rtl/can_ctl_stat.sv
module can_ctl_stat
  import can_ctl_pkg::*;
#(
  parameter int MSG_CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_t              cmd,
  input  logic              rd_int,
  input  logic              wr_txb0,
  input  logic              op_mode,
  input  logic              leave_rst,
  input  logic              tx_done,
  input  logic              rx_begin,
  input  logic              rx_stored,
  input  logic              rx_overrun,
  input  logic              rx_reject,
  output logic [DATA_W-1:0] stat,
  output logic [DATA_W-1:0] ireg,
  output logic              rx_release
);
  localparam logic [MSG_CNT_W-1:0] CNT_MAX = '1;

  logic [MSG_CNT_W-1:0] cnt, cnt_n;
  logic [DATA_W-1:0]    st_n, ir_n;
  logic                 rel_ok;

  assign rel_ok = cmd.rel && (cnt != '0);

  always_comb begin
    cnt_n = cnt;
    if (rel_ok)                         cnt_n = cnt_n - 1'b1;
    if (leave_rst)                      cnt_n = '0;
    if (rx_stored && cnt_n != CNT_MAX)  cnt_n = cnt_n + 1'b1;
  end

  always_comb begin
    st_n = stat;
    ir_n = rd_int ? '0 : ireg;
    // command order: transmit, release (via count), clear-overrun
    if (cmd.tx) begin
      st_n[ST_TXBUF] = 1'b0;
      st_n[ST_TXCMP] = 1'b0;
    end
    if (cmd.clr) begin
      st_n[ST_OVR] = 1'b0;
      ir_n[IR_OVR] = 1'b0;
    end
    if (wr_txb0 && op_mode) st_n[ST_TXACT] = 1'b1;
    if (tx_done) begin
      st_n[ST_TXBUF] = 1'b1;
      st_n[ST_TXCMP] = 1'b1;
      st_n[ST_TXACT] = 1'b0;
      ir_n[IR_TX]    = 1'b1;
    end
    if (rx_overrun) begin
      st_n[ST_OVR] = 1'b1;
      ir_n[IR_OVR] = 1'b1;
    end
    if (rx_begin) st_n[ST_RXACT] = 1'b1;
    if (rx_stored || rx_overrun || rx_reject) st_n[ST_RXACT] = 1'b0;
    if (rx_stored) ir_n[IR_RX] = 1'b1;
    if (cnt_n == '0)  ir_n[IR_RX] = 1'b0;
    else if (rd_int)  ir_n[IR_RX] = 1'b1;
    st_n[ST_RXBUF] = (cnt_n != '0);
    st_n[DATA_W-1:ST_TXACT+1] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat       <= STAT_RST;
      ireg       <= '0;
      cnt        <= '0;
      rx_release <= 1'b0;
    end else begin
      stat       <= st_n;
      ireg       <= ir_n;
      cnt        <= cnt_n;
      rx_release <= rel_ok;
    end
  end

  p_tx_clears_cmp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.tx && !tx_done) |=> (stat[ST_TXBUF:ST_TXCMP] == 2'b00));
  p_tx_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> (stat[ST_TXBUF:ST_TXCMP] == 2'b11 && ireg[IR_TX] && !stat[ST_TXACT]));
  p_ovr_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.clr && !rx_overrun) |=> (!stat[ST_OVR] && !ireg[IR_OVR]));
  p_ovr_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> (stat[ST_OVR] && ireg[IR_OVR]));
  p_rx_outcome_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stored || rx_reject || rx_overrun) |=> !stat[ST_RXACT]);
endmodule

// File: rtl/can_ctl_core.sv
module can_ctl_core
  import can_ctl_pkg::*;
#(
  parameter int MSG_CNT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic [MODE_W-1:0] mode,
  output logic              tx_req,
  input  logic              tx_done,
  input  logic              rx_begin,
  input  logic              rx_stored,
  input  logic              rx_overrun,
  input  logic              rx_reject,
  output logic              rx_release,
  output logic              op_enter
);
  logic              wr_mode, wr_cmd, wr_ien, wr_txb0, rd_int, leave_rst;
  logic [DATA_W-1:0] stat, ireg, ien;
  cmd_t              cmd;

  can_ctl_regbus u_bus (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .mode(mode), .stat(stat), .ireg(ireg), .ien(ien),
    .wr_mode(wr_mode), .wr_cmd(wr_cmd), .wr_ien(wr_ien), .wr_txb0(wr_txb0),
    .rd_int(rd_int), .rdata(rdata)
  );

  can_ctl_mode u_mode (
    .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .wr_ien(wr_ien),
    .wdata(wdata), .mode(mode), .ien(ien), .leave_rst(leave_rst),
    .op_enter(op_enter)
  );

  can_ctl_cmd u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd),
    .cmd_bits({wdata[3], wdata[2], wdata[0]}), .cmd(cmd), .tx_req(tx_req)
  );

  can_ctl_stat #(.MSG_CNT_W(MSG_CNT_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .rd_int(rd_int), .wr_txb0(wr_txb0),
    .op_mode(!mode[0]), .leave_rst(leave_rst), .tx_done(tx_done),
    .rx_begin(rx_begin), .rx_stored(rx_stored), .rx_overrun(rx_overrun),
    .rx_reject(rx_reject), .stat(stat), .ireg(ireg), .rx_release(rx_release)
  );

  assign irq = |(ien & ireg);

  p_irq_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
  p_enter_drops_rx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_enter && !$past(rx_stored)) |-> !ireg[IR_RX]);
endmodule

// File: tb/sim_can_ctl_core.sv
module sim_can_ctl_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, tx_req, rx_release, op_enter;
  logic [4:0] mode;
  logic       tx_done = 1'b0, rx_begin = 1'b0, rx_stored = 1'b0;
  logic       rx_overrun = 1'b0, rx_reject = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  can_ctl_core u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .mode(mode), .tx_req(tx_req),
    .tx_done(tx_done), .rx_begin(rx_begin), .rx_stored(rx_stored),
    .rx_overrun(rx_overrun), .rx_reject(rx_reject), .rx_release(rx_release),
    .op_enter(op_enter)
  );

  // monitor: R12 read data one cycle after rd_en
  always @(posedge clk) pend <= rd_en && rst_n;
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_bad++;
        $display("FAIL %s: rdata actual %02h expected %02h", t, rdata, e);
      end
    end
  end

  task automatic chk(input string t, input logic [7:0] act, input logic [7:0] e);
    n_chk++;
    if (act !== e) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", t, act, e);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [7:0] e, input string t);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  // 0 tx_done, 1 begin, 2 stored, 3 overrun, 4 reject
  task automatic ev(input int k);
    @(negedge clk);
    case (k)
      0: tx_done = 1'b1;
      1: rx_begin = 1'b1;
      2: rx_stored = 1'b1;
      3: rx_overrun = 1'b1;
      default: rx_reject = 1'b1;
    endcase
    @(negedge clk);
    tx_done = 1'b0; rx_begin = 1'b0; rx_stored = 1'b0;
    rx_overrun = 1'b0; rx_reject = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd(5'h00, 8'h01, "R1 mode");
    rd(5'h02, 8'h3C, "R1 status");
    rd(5'h03, 8'h00, "R1 int");
    // R7 mode mask, then R9 leave reset
    wr(5'h00, 8'hE9);
    chk("R9 no op_enter", {7'b0, op_enter}, 8'h00);
    rd(5'h00, 8'h09, "R7 mode mask");
    wr(5'h00, 8'h08);
    chk("R9 op_enter", {7'b0, op_enter}, 8'h01);
    // R7 ignored writes, command read
    wr(5'h02, 8'hFF);
    rd(5'h02, 8'h3C, "R7 status write");
    wr(5'h03, 8'hFF);
    rd(5'h03, 8'h00, "R7 int write");
    rd(5'h01, 8'h00, "R7 cmd read");
    // R3 transmit
    wr(5'h04, 8'h02);
    wr(5'h01, 8'h01);
    chk("R3 tx_req", {7'b0, tx_req}, 8'h01);
    rd(5'h02, 8'h30, "R3 status after cmd");
    ev(0);
    rd(5'h02, 8'h1C, "R3 status after done");
    chk("R2 irq tx", {7'b0, irq}, 8'h01);
    rd(5'h03, 8'h02, "R11 int read");
    chk("R2 irq cleared", {7'b0, irq}, 8'h00);
    rd(5'h03, 8'h00, "R11 int after clear");
    // R8 tx buffer byte in operating mode
    wr(5'h10, 8'h55);
    rd(5'h02, 8'h3C, "R8 txbuf op");
    // R6 receive activity
    ev(4);
    rd(5'h02, 8'h2C, "R6 reject");
    ev(1);
    rd(5'h02, 8'h3C, "R6 begin");
    ev(2);
    rd(5'h02, 8'h2D, "R6 stored");
    ev(2);
    wr(5'h04, 8'h01);
    chk("R2 irq rx", {7'b0, irq}, 8'h01);
    rd(5'h03, 8'h01, "R11 read one");
    rd(5'h03, 8'h01, "R11 reasserted");
    // R4 release
    wr(5'h01, 8'h04);
    chk("R4 release pulse", {7'b0, rx_release}, 8'h01);
    rd(5'h02, 8'h2D, "R4 one left");
    wr(5'h01, 8'h04);
    rd(5'h02, 8'h2C, "R4 empty status");
    rd(5'h03, 8'h00, "R4 empty int");
    chk("R2 irq empty", {7'b0, irq}, 8'h00);
    wr(5'h01, 8'h04);
    chk("R4 release at zero", {7'b0, rx_release}, 8'h00);
    rd(5'h02, 8'h2C, "R4 status at zero");
    // R5 overrun
    ev(3);
    rd(5'h02, 8'h2E, "R6 overrun");
    wr(5'h04, 8'h08);
    chk("R2 irq ovr", {7'b0, irq}, 8'h01);
    wr(5'h01, 8'h08);
    chk("R5 irq after clear", {7'b0, irq}, 8'h00);
    rd(5'h02, 8'h2C, "R5 status");
    rd(5'h03, 8'h00, "R5 int");
    // R10 combined command
    ev(2);
    ev(3);
    rd(5'h02, 8'h2F, "R10 before");
    wr(5'h01, 8'h0D);
    chk("R10 tx_req", {7'b0, tx_req}, 8'h01);
    chk("R10 release", {7'b0, rx_release}, 8'h01);
    rd(5'h02, 8'h20, "R10 status");
    ev(0);
    rd(5'h02, 8'h0C, "R10 after done");
    rd(5'h03, 8'h02, "R10 int");
    // R8 in reset mode, R9 flush
    ev(2);
    wr(5'h00, 8'h01);
    wr(5'h10, 8'hAA);
    rd(5'h02, 8'h0D, "R8 txbuf reset mode");
    wr(5'h00, 8'h00);
    chk("R9 op_enter again", {7'b0, op_enter}, 8'h01);
    rd(5'h02, 8'h0C, "R9 status flush");
    rd(5'h03, 8'h00, "R9 int flush");
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule